// File: doc/BRIEF.md
# Committed Transmit Byte Buffer

This block is a 32-byte transmit buffer that sits between a host bus and a serial protocol engine. The host writes bytes or 16-bit words to one fixed data address. A word access stores its low byte first and then its high byte. Written bytes stay hidden from the engine until the host issues a transmit command. That command commits every byte written in earlier cycles. It may also carry an end-of-frame flag, which tags the last committed byte so the engine knows that the frame closes there.

The engine takes committed bytes one at a time from the head of the buffer. The block raises a pool-ready pulse when the buffer has fully drained, so that all 32 bytes are free for the next block of data. It raises an all-sent pulse when the engine reports that its last bit has left and the buffer is empty. A global mode input lets a DMA request/acknowledge handshake fill the buffer in place of the host. Bus-width rules are enforced: an access that breaks them, or that does not fit, is dropped and a sticky error flag is set.

Top module: `txf_top`

## Requirements
- R1: After reset the buffer is empty: tx_avail, tx_last, dma_req, wr_err, irq_pool_ready and irq_all_sent are all 0.
- R2: Stored bytes reach the engine (tx_avail=1) only after cmd_xtf. A command commits only the bytes written in earlier cycles, so a byte written in the same cycle as cmd_xtf stays uncommitted.
- R3: A host write whose host_addr differs from DATA_ADDR (default 0x10) stores nothing.
- R4: A word write (host_word=1) stores host_wdata[7:0] and then host_wdata[15:8]. The engine receives bytes in the order they were stored: tx_data shows the head byte, and tx_pop advances to the next one.
- R5: When bus16=0, word writes are rejected. When bus16=1, a byte write (host_word=0) closes the frame, and any further write is rejected until a cmd_xtf with cmd_eof=1. A rejected write stores nothing and sets wr_err.
- R6: A write that would push occupancy above 32 bytes is rejected and sets wr_err. Occupancy is judged before a tx_pop in the same cycle. wr_err stays set until the next cmd_xtf, which clears it unless a rejection occurs in that same cycle.
- R7: When cmd_xtf is given with cmd_eof=1 and new bytes are present, the last byte committed carries tx_last=1 while it is the head. Every other byte shows tx_last=0.
- R8: irq_pool_ready pulses for one cycle, in the cycle after a tx_pop that leaves the buffer holding 0 bytes.
- R9: irq_all_sent pulses for one cycle, in the cycle after tx_shift_done is seen while the buffer holds 0 bytes. It stays 0 if bytes remain.
- R10: When dma_en=1, host writes are ignored. dma_req is 1 while there is room for one access of bus width (2 bytes if bus16=1, else 1) and no closed frame. dma_ack stores host_wdata as an access of bus width.
- R11: A tx_pop while no committed byte is present changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus16 | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| dma_en | input | 1 | 1 = buffer filled by DMA handshake |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host address |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_wdata | input | 16 | Write data (host or DMA) |
| cmd_xtf | input | 1 | Transmit command: commit stored bytes |
| cmd_eof | input | 1 | End-of-frame flag of the transmit command |
| dma_ack | input | 1 | DMA transfer strobe |
| dma_req | output | 1 | DMA request |
| tx_pop | input | 1 | Engine takes the head byte |
| tx_shift_done | input | 1 | Engine reports its last bit has left |
| tx_avail | output | 1 | Committed byte present |
| tx_data | output | 8 | Head byte |
| tx_last | output | 1 | Head byte ends the frame |
| irq_pool_ready | output | 1 | Buffer drained pulse |
| irq_all_sent | output | 1 | All data sent pulse |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
A host write and an engine pop can fall in the same cycle, and so can a write and a transmit command. The bench drives each pair in one cycle. In the first case it checks that pool-ready stays low, because the buffer is not empty afterwards. It also checks that, with the buffer full, the write is still rejected, since space is judged before the pop. In the second case it checks that the new byte stays hidden until a later command and is then delivered in order.

// File: rtl/txf_pkg.sv
package txf_pkg;
    // One store request: up to two bytes, low byte first
    typedef struct packed {
        logic        en;
        logic        two;
        logic [15:0] data;
    } txf_push_t;
endpackage

// File: rtl/txf_wr_ctrl.sv
module txf_wr_ctrl #(
    parameter int DEPTH = 32,
    parameter int PTR_W = 6
) (
    input  logic                 bus16,
    input  logic                 dma_en,
    input  logic                 host_wr,
    input  logic                 addr_hit,
    input  logic                 host_word,
    input  logic                 dma_ack,
    input  logic [15:0]          wdata,
    input  logic [PTR_W-1:0]     total,
    input  logic                 closed,
    output txf_pkg::txf_push_t   push,
    output logic                 reject
);
    localparam logic [PTR_W:0] CAP = DEPTH[PTR_W:0];

    logic             src_host;
    logic             src_dma;
    logic             attempt;
    logic             is_word;
    logic [PTR_W:0]   need;
    logic             no_room;
    logic             bad_width;

    always_comb begin
        src_host  = host_wr && addr_hit && !dma_en;
        src_dma   = dma_ack && dma_en;
        attempt   = src_host || src_dma;
        is_word   = src_dma ? bus16 : host_word;
        need      = {{(PTR_W-1){1'b0}}, is_word, !is_word};
        no_room   = ({1'b0, total} + need) > CAP;
        bad_width = !bus16 && is_word;
        reject    = attempt && (bad_width || closed || no_room);
        push.en   = attempt && !reject;
        push.two  = is_word;
        push.data = wdata;
    end
endmodule

// File: rtl/txf_store.sv
module txf_store #(
    parameter int DEPTH = 32,
    parameter int PTR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  txf_pkg::txf_push_t  push,
    input  logic [PTR_W-1:0]    wr_ptr,
    input  logic [PTR_W-1:0]    rd_ptr,
    input  logic                mark_en,
    input  logic [PTR_W-1:0]    mark_ptr,
    output logic [7:0]          head_data,
    output logic                head_last
);
    localparam int AW = PTR_W - 1;

    logic [7:0]       mem_q [DEPTH];
    logic [DEPTH-1:0] last_q;
    logic [AW-1:0]    wa0;
    logic [AW-1:0]    wa1;

    assign wa0 = wr_ptr[AW-1:0];
    assign wa1 = wa0 + AW'(1);

    always_ff @(posedge clk) begin
        if (push.en) begin
            mem_q[wa0] <= push.data[7:0];
            if (push.two) mem_q[wa1] <= push.data[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            if (push.en) begin
                last_q[wa0] <= 1'b0;
                if (push.two) last_q[wa1] <= 1'b0;
            end
            if (mark_en) last_q[mark_ptr[AW-1:0]] <= 1'b1;
        end
    end

    assign head_data = mem_q[rd_ptr[AW-1:0]];
    assign head_last = last_q[rd_ptr[AW-1:0]];
endmodule

// File: rtl/txf_top.sv
module txf_top #(
    parameter int               DEPTH     = 32,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic              dma_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_word,
    input  logic [15:0]       host_wdata,
    input  logic              cmd_xtf,
    input  logic              cmd_eof,
    input  logic              dma_ack,
    output logic              dma_req,
    input  logic              tx_pop,
    input  logic              tx_shift_done,
    output logic              tx_avail,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq_pool_ready,
    output logic              irq_all_sent,
    output logic              wr_err
);
    localparam int             PTR_W = $clog2(DEPTH) + 1;
    localparam logic [PTR_W:0] CAP   = DEPTH[PTR_W:0];

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] cmt;
        logic [PTR_W-1:0] rd;
        logic             closed;
        logic             err;
        logic             irq_pr;
        logic             irq_as;
    } txf_state_t;

    txf_state_t         st_d, st_q;
    txf_pkg::txf_push_t push;
    logic               reject;
    logic [PTR_W-1:0]   total;
    logic [PTR_W-1:0]   cmt_cnt;
    logic               pop_ok;
    logic               addr_hit;
    logic               mark_en;
    logic [PTR_W-1:0]   mark_ptr;
    logic [7:0]         head_data;
    logic               head_last;
    logic [PTR_W:0]     dma_need;

    assign total    = st_q.wr - st_q.rd;
    assign cmt_cnt  = st_q.cmt - st_q.rd;
    assign addr_hit = (host_addr == DATA_ADDR);

    txf_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr_ctrl (
        .bus16     (bus16),
        .dma_en    (dma_en),
        .host_wr   (host_wr),
        .addr_hit  (addr_hit),
        .host_word (host_word),
        .dma_ack   (dma_ack),
        .wdata     (host_wdata),
        .total     (total),
        .closed    (st_q.closed),
        .push      (push),
        .reject    (reject)
    );

    always_comb begin
        st_d        = st_q;
        st_d.irq_pr = 1'b0;
        st_d.irq_as = 1'b0;
        pop_ok      = tx_pop && (cmt_cnt != '0);
        mark_en     = cmd_xtf && cmd_eof && (st_q.wr != st_q.cmt);
        mark_ptr    = st_q.wr - PTR_W'(1);

        if (cmd_xtf) begin
            st_d.cmt = st_q.wr;
            st_d.err = 1'b0;
            if (cmd_eof) st_d.closed = 1'b0;
        end
        if (push.en) begin
            st_d.wr = st_q.wr + (push.two ? PTR_W'(2) : PTR_W'(1));
            if (bus16 && !push.two) st_d.closed = 1'b1;
        end
        if (reject) st_d.err = 1'b1;
        if (pop_ok) begin
            st_d.rd = st_q.rd + PTR_W'(1);
            if (st_d.wr == st_d.rd) st_d.irq_pr = 1'b1;
        end
        if (tx_shift_done && (total == '0)) st_d.irq_as = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    txf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wr_ptr    (st_q.wr),
        .rd_ptr    (st_q.rd),
        .mark_en   (mark_en),
        .mark_ptr  (mark_ptr),
        .head_data (head_data),
        .head_last (head_last)
    );

    assign dma_need       = {{(PTR_W-1){1'b0}}, bus16, !bus16};
    assign dma_req        = dma_en && !st_q.closed && (({1'b0, total} + dma_need) <= CAP);
    assign tx_avail       = (cmt_cnt != '0);
    assign tx_data        = head_data;
    assign tx_last        = head_last && tx_avail;
    assign irq_pool_ready = st_q.irq_pr;
    assign irq_all_sent   = st_q.irq_as;
    assign wr_err         = st_q.err;
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
    parameter int DEPTH = 32,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] total,
    input logic             tx_avail,
    input logic             cmd_xtf,
    input logic             tx_pop,
    input logic             push_en,
    input logic             host_wr,
    input logic             addr_hit,
    input logic             dma_en,
    input logic             dma_req,
    input logic             tx_shift_done,
    input logic             irq_pool_ready,
    input logic             irq_all_sent,
    input logic             wr_err
);
    localparam logic [PTR_W-1:0] CAPN = DEPTH[PTR_W-1:0];

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        total <= CAPN);

    p_full_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (total == CAPN && host_wr && addr_hit && !dma_en) |=> wr_err);

    p_hidden_until_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_avail && !cmd_xtf) |=> !tx_avail);

    p_pool_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pool_ready |-> (total == '0));

    p_sent_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_all_sent |-> $past(tx_shift_done));

    p_dma_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_en && total < CAPN));

    p_idle_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_avail && tx_pop && !push_en) |=> $stable(total));
endmodule

bind txf_top txf_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .total          (total),
    .tx_avail       (tx_avail),
    .cmd_xtf        (cmd_xtf),
    .tx_pop         (tx_pop),
    .push_en        (push.en),
    .host_wr        (host_wr),
    .addr_hit       (addr_hit),
    .dma_en         (dma_en),
    .dma_req        (dma_req),
    .tx_shift_done  (tx_shift_done),
    .irq_pool_ready (irq_pool_ready),
    .irq_all_sent   (irq_all_sent),
    .wr_err         (wr_err)
);

// File: tb/txf_top_tb_top.sv
module txf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus16 = 1'b0, dma_en = 1'b0;
    logic        host_wr = 1'b0, host_word = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [15:0] host_wdata = 16'h0;
    logic        cmd_xtf = 1'b0, cmd_eof = 1'b0, dma_ack = 1'b0;
    logic        tx_pop = 1'b0, tx_shift_done = 1'b0;
    logic        dma_req, tx_avail, tx_last, irq_pool_ready, irq_all_sent, wr_err;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q [64];
    int exp_n;

    always #4 clk = ~clk;

    txf_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus16(bus16), .dma_en(dma_en),
        .host_wr(host_wr), .host_addr(host_addr), .host_word(host_word),
        .host_wdata(host_wdata), .cmd_xtf(cmd_xtf), .cmd_eof(cmd_eof),
        .dma_ack(dma_ack), .dma_req(dma_req), .tx_pop(tx_pop),
        .tx_shift_done(tx_shift_done), .tx_avail(tx_avail), .tx_data(tx_data),
        .tx_last(tx_last), .irq_pool_ready(irq_pool_ready),
        .irq_all_sent(irq_all_sent), .wr_err(wr_err)
    );

    // {word, data}: words on the 16-bit bus, odd final byte last
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 16'hA201}, {1'b1, 16'h5C3B}, {1'b1, 16'h00FF},
        {1'b1, 16'h7E80}, {1'b1, 16'h1234}, {1'b0, 16'h00C7}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one operation cycle: drive at a falling edge, release at the next
    task automatic step(input logic w, input logic [7:0] a, input logic wd,
                        input logic [15:0] d, input logic c, input logic e,
                        input logic p, input logic sd, input logic ack);
        @(negedge clk);
        host_wr = w; host_addr = a; host_word = wd; host_wdata = d;
        cmd_xtf = c; cmd_eof = e; tx_pop = p; tx_shift_done = sd; dma_ack = ack;
        @(negedge clk);
        host_wr = 0; host_word = 0; cmd_xtf = 0; cmd_eof = 0;
        tx_pop = 0; tx_shift_done = 0; dma_ack = 0;
    endtask

    task automatic wr(input logic wd, input logic [15:0] d);
        step(1, 8'h10, wd, d, 0, 0, 0, 0, 0);
    endtask
    task automatic commit(input logic e);
        step(0, 8'h10, 0, 16'h0, 1, e, 0, 0, 0);
    endtask
    task automatic pop();
        step(0, 8'h10, 0, 16'h0, 0, 0, 1, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 tx_avail", tx_avail, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 wr_err", wr_err, 0);
        chk("R1 irqs", {irq_pool_ready, irq_all_sent, tx_last}, 0);

        // vector table: 16-bit bus, words then a closing byte
        bus16 = 1;
        exp_n = 0;
        foreach (VEC[i]) begin
            wr(VEC[i][16], VEC[i][15:0]);
            exp_q[exp_n] = VEC[i][7:0]; exp_n++;
            if (VEC[i][16]) begin exp_q[exp_n] = VEC[i][15:8]; exp_n++; end
            chk("R2 hidden before command", tx_avail, 0);
        end
        commit(1);
        for (int k = 0; k < exp_n; k++) begin
            chk("R4 order", tx_data, exp_q[k]);
            chk("R7 last flag", tx_last, (k == exp_n - 1));
            pop();
        end
        chk("R8 pool ready after drain", irq_pool_ready, 1);
        chk("R11 empty after drain", tx_avail, 0);
        @(negedge clk);
        chk("R8 single pulse", irq_pool_ready, 0);

        // R9: all-sent only when empty
        step(0, 8'h10, 0, 0, 0, 0, 0, 1, 0);
        chk("R9 all sent when empty", irq_all_sent, 1);
        wr(1, 16'h2211);
        step(0, 8'h10, 0, 0, 0, 0, 0, 1, 0);
        chk("R9 no all sent with data", irq_all_sent, 0);
        do_reset();

        // R3: wrong address stores nothing
        bus16 = 0;
        step(1, 8'h11, 0, 16'h0055, 0, 0, 0, 0, 0);
        commit(1);
        chk("R3 other address ignored", tx_avail, 0);

        // R5: word write on 8-bit bus rejected
        wr(1, 16'h3344);
        chk("R5 word on 8-bit bus error", wr_err, 1);
        commit(1);
        chk("R5 nothing stored", tx_avail, 0);
        chk("R6 error cleared by command", wr_err, 0);

        // R5: 16-bit bus, byte closes frame
        bus16 = 1;
        wr(0, 16'h0066);
        wr(1, 16'h7788);
        chk("R5 write after closing byte error", wr_err, 1);
        commit(1);
        chk("R5 closing byte", tx_data, 8'h66);
        pop();
        chk("R5 rejected word absent", tx_avail, 0);
        wr(1, 16'h9A99);
        chk("R5 frame reopened after eof", wr_err, 0);
        do_reset();

        // R6: capacity, with same-cycle pop at full
        bus16 = 0;
        for (int k = 0; k < 32; k++) wr(0, 16'(k + 8'h40));
        chk("R6 32 bytes accepted", wr_err, 0);
        wr(0, 16'h00EE);
        chk("R6 33rd byte rejected", wr_err, 1);
        commit(0);
        step(1, 8'h10, 0, 16'h00DD, 0, 0, 1, 0, 0);
        chk("R6 full judged before pop", wr_err, 1);
        for (int k = 1; k < 32; k++) begin
            if (k == 1 || k == 31) chk("R6 stored byte", tx_data, 8'(k + 8'h40));
            pop();
        end
        chk("R6 no extra bytes", tx_avail, 0);
        do_reset();

        // R2 / R8: write with pop, write with command
        bus16 = 0;
        wr(0, 16'h00A1);
        commit(1);
        step(1, 8'h10, 0, 16'h00B2, 0, 0, 1, 0, 0);
        chk("R8 no pool ready while bytes remain", irq_pool_ready, 0);
        chk("R2 new byte hidden", tx_avail, 0);
        step(1, 8'h10, 0, 16'h00C3, 1, 0, 0, 0, 0);
        chk("R2 commit covers older byte", tx_data, 8'hB2);
        pop();
        chk("R2 same-cycle byte uncommitted", tx_avail, 0);
        commit(1);
        chk("R2 later command commits", tx_data, 8'hC3);
        chk("R7 eof on last committed", tx_last, 1);
        pop();

        // R11: pop on empty
        pop();
        wr(0, 16'h005A);
        commit(1);
        chk("R11 empty pop had no effect", tx_data, 8'h5A);
        do_reset();

        // R10: DMA fill on the 16-bit bus
        bus16 = 1; dma_en = 1;
        @(negedge clk);
        chk("R10 dma_req with room", dma_req, 1);
        wr(1, 16'h4321);
        commit(1);
        chk("R10 host write ignored", tx_avail, 0);
        for (int k = 0; k < 16; k++) step(0, 8'h10, 0, 16'(k * 16'h0202 + 16'h0100), 0, 0, 0, 0, 1);
        chk("R10 dma_req low when full", dma_req, 0);
        commit(1);
        chk("R10 dma low byte", tx_data, 8'h00);
        pop();
        chk("R10 dma high byte", tx_data, 8'h01);
        dma_en = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule